// File: doc/BRIEF.md
# Control-Transfer Alignment Trap Unit

This execute-stage block resolves the destination of every control transfer in a small 64-bit core: direct jumps, register-indirect jumps, conditional branches and machine-mode return. It also decides whether a taken transfer must raise an instruction-address-misaligned exception. The outcome depends on whether compressed instructions are enabled at that moment. The block holds that enable bit itself. A write to the ISA register may change the bit, but a request to turn compressed support off is refused when the instruction after the write would then be fetched from a misaligned address.

For each accepted operation, the block reports one cycle later:
- the next fetch address;
- whether the destination register may be written;
- on a trap, the exception cause, the exception PC and the trap value.

When compressed support is off, a machine-mode return ignores bit 1 of the saved PC.

Top module: `xfer_align_unit`

## Requirements
- R1: A register-indirect jump (kind 1) targets rs1 plus the immediate with bit 0 of the sum cleared, so an odd offset never causes a trap on its own.
- R2: A direct jump (kind 0) and a taken branch (kind 2, taken flag high) target PC plus the immediate. A branch that is not taken continues at PC plus 4. The target appears on next_pc.
- R3: When compressed support is off, a taken jump or branch whose target has bit 1 set raises trap_valid. With compressed support on, the same target gives no trap.
- R4: A branch that is not taken never raises trap_valid, whatever its immediate.
- R5: rd_we is high only for a jump (kind 0 or 1) that does not trap. It is low on a trap and for every other kind.
- R6: On a trap, trap_cause is 0, trap_epc is the PC of the jump or branch itself, and trap_tval is the full misaligned target.
- R7: An ISA-register write (kind 4) sets the compressed enable from bit 2 of the write value and continues at PC plus 4. A write that would clear the bit is ignored, and the bit stays 1, when bit 1 of PC plus 4 is set.
- R8: A return (kind 3) continues at mepc with bit 0 cleared. Bit 1 is also cleared when compressed support is off. A return never traps and never writes a register.
- R9: Reset sets c_enable to 1 and clears out_valid, rd_we and trap_valid.
- R10: All results are registered. They appear one clock edge after in_valid is sampled high, with out_valid high for that one cycle. Kinds 5 to 7, or in_valid low, give out_valid, rd_we and trap_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_kind | input | 3 | 0 jump, 1 indirect jump, 2 branch, 3 return, 4 ISA-register write |
| in_taken | input | 1 | Branch outcome |
| in_pc | input | XLEN | Address of the operation |
| in_rs1 | input | XLEN | Base register for an indirect jump |
| in_imm | input | XLEN | Sign-extended offset |
| in_isa_wdata | input | XLEN | ISA-register write value (bit 2 is the compressed enable) |
| in_mepc | input | XLEN | Saved exception PC used by a return |
| out_valid | output | 1 | Result valid |
| next_pc | output | XLEN | Resolved next fetch address |
| rd_we | output | 1 | Destination register write allowed |
| trap_valid | output | 1 | Misaligned-target exception |
| trap_cause | output | CAUSE_W | Exception cause |
| trap_epc | output | XLEN | Exception PC |
| trap_tval | output | XLEN | Trap value (faulting target) |
| c_enable | output | 1 | Current compressed-instruction enable |

## Verification
The bench builds the block with its default parameters: XLEN of 64 and CAUSE_W of 6. At full width, a sign-extended negative offset yields a target below the PC. An indirect jump whose base sits two bytes under the top of the address space wraps round to a low address with bit 1 set, so the bench also sees a misaligned target reached through carry overflow. A single run steps the enable bit through on, refused-off, off and back on. Each alignment rule is therefore exercised under both settings.

// File: rtl/xfer_align_unit.sv
module xfer_align_unit #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         in_kind,
  input  logic               in_taken,
  input  logic [XLEN-1:0]    in_pc,
  input  logic [XLEN-1:0]    in_rs1,
  input  logic [XLEN-1:0]    in_imm,
  input  logic [XLEN-1:0]    in_isa_wdata,
  input  logic [XLEN-1:0]    in_mepc,
  output logic               out_valid,
  output logic [XLEN-1:0]    next_pc,
  output logic               rd_we,
  output logic               trap_valid,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_epc,
  output logic [XLEN-1:0]    trap_tval,
  output logic               c_enable
);
  localparam logic [2:0] K_JAL  = 3'd0;
  localparam logic [2:0] K_JALR = 3'd1;
  localparam logic [2:0] K_BR   = 3'd2;
  localparam logic [2:0] K_RET  = 3'd3;
  localparam logic [2:0] K_ISA  = 3'd4;
  localparam int         C_BIT  = 2;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGNED = '0;

  logic [XLEN-1:0] seq_pc, rel_tgt, jalr_sum, tgt;
  logic            is_jump, moves, misaligned, known, c_next;

  assign seq_pc   = in_pc + XLEN'(4);
  assign rel_tgt  = in_pc + in_imm;
  assign jalr_sum = in_rs1 + in_imm;
  assign is_jump  = (in_kind == K_JAL) || (in_kind == K_JALR);
  assign moves    = is_jump || ((in_kind == K_BR) && in_taken);
  assign known    = in_kind <= K_ISA;

  always_comb begin
    case (in_kind)
      K_JAL:   tgt = rel_tgt;
      K_JALR:  tgt = {jalr_sum[XLEN-1:1], 1'b0};
      K_BR:    tgt = in_taken ? rel_tgt : seq_pc;
      K_RET:   tgt = {in_mepc[XLEN-1:2], in_mepc[1] & c_enable, 1'b0};
      default: tgt = seq_pc;
    endcase
  end

  assign misaligned = moves && !c_enable && tgt[1];

  always_comb begin
    c_next = c_enable;
    if (in_valid && in_kind == K_ISA) begin
      if (in_isa_wdata[C_BIT])
        c_next = 1'b1;
      else if (!seq_pc[1])
        c_next = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      rd_we      <= 1'b0;
      trap_valid <= 1'b0;
      c_enable   <= 1'b1;
      next_pc    <= '0;
      trap_cause <= '0;
      trap_epc   <= '0;
      trap_tval  <= '0;
    end else begin
      out_valid  <= in_valid && known;
      rd_we      <= in_valid && is_jump && !misaligned;
      trap_valid <= in_valid && misaligned;
      c_enable   <= c_next;
      if (in_valid && known)
        next_pc <= tgt;
      if (in_valid && misaligned) begin
        trap_cause <= CAUSE_MISALIGNED;
        trap_epc   <= in_pc;
        trap_tval  <= tgt;
      end
    end
  end
endmodule

module xfer_align_unit_chk #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [2:0]         in_kind,
  input logic               in_taken,
  input logic [XLEN-1:0]    in_pc,
  input logic [XLEN-1:0]    in_isa_wdata,
  input logic               rd_we,
  input logic               trap_valid,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic [XLEN-1:0]    trap_epc,
  input logic [XLEN-1:0]    trap_tval,
  input logic               c_enable
);
  // R5
  trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !rd_we);

  // R6
  trap_cause_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> trap_cause == '0);

  // R6
  trap_epc_is_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> trap_epc == $past(in_pc));

  // R3
  trap_needs_c_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (!c_enable && trap_tval[1]));

  // R4
  untaken_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 3'd2 && !in_taken) |=> !trap_valid);

  // R7
  refused_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 3'd4 && !in_isa_wdata[2] && in_pc[1]) |=> c_enable);

  // R7
  c_change_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(c_enable) |-> $past(in_valid && in_kind == 3'd4));
endmodule

bind xfer_align_unit xfer_align_unit_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
  .in_taken(in_taken), .in_pc(in_pc), .in_isa_wdata(in_isa_wdata),
  .rd_we(rd_we), .trap_valid(trap_valid), .trap_cause(trap_cause),
  .trap_epc(trap_epc), .trap_tval(trap_tval), .c_enable(c_enable)
);

// File: tb/xfer_align_unit_bench.sv
`timescale 1ns/1ps
module xfer_align_unit_bench;
  localparam int XLEN = 64;
  localparam logic [63:0] B  = 64'h8000_0100;
  localparam logic [63:0] T0 = 64'h8000_0200;
  localparam logic [63:0] M  = 64'h8000_0203;
  localparam logic [63:0] Z  = 64'd0;
  localparam logic [63:0] NEG2 = 64'hFFFF_FFFF_FFFF_FFFE;

  typedef struct packed {
    logic [2:0]  kind;
    logic        taken;
    logic [63:0] pc, rs1, imm, wdata, mepc, exp_next;
    logic        exp_trap, exp_rdwe, exp_c;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 1'b0, B,     T0, 64'd2, Z,     Z, T0+2,  1'b0, 1'b1, 1'b1}, // R1 C on +2
    '{3'd1, 1'b0, B,     T0, 64'd1, Z,     Z, T0,    1'b0, 1'b1, 1'b1}, // R1 +1
    '{3'd1, 1'b0, B,     T0, 64'd3, Z,     Z, T0+2,  1'b0, 1'b1, 1'b1}, // R1 +3
    '{3'd0, 1'b0, B,     Z,  64'd10,Z,     Z, B+10,  1'b0, 1'b1, 1'b1}, // R2 R3
    '{3'd2, 1'b1, B,     Z,  64'd6, Z,     Z, B+6,   1'b0, 1'b0, 1'b1}, // R2
    '{3'd2, 1'b0, B,     Z,  64'd6, Z,     Z, B+4,   1'b0, 1'b0, 1'b1}, // R4
    '{3'd3, 1'b0, B,     Z,  Z,     Z,     M, M-1,   1'b0, 1'b0, 1'b1}, // R8 C on
    '{3'd4, 1'b0, B+6,   Z,  Z,     Z,     Z, B+10,  1'b0, 1'b0, 1'b1}, // R7 refused
    '{3'd4, 1'b0, B+8,   Z,  Z,     Z,     Z, B+12,  1'b0, 1'b0, 1'b0}, // R7 accepted
    '{3'd1, 1'b0, B,     T0, 64'd2, Z,     Z, T0+2,  1'b1, 1'b0, 1'b0}, // R3 R5 R6
    '{3'd1, 1'b0, B,     T0, 64'd1, Z,     Z, T0,    1'b0, 1'b1, 1'b0}, // R1 C off +1
    '{3'd1, 1'b0, B,     T0, 64'd3, Z,     Z, T0+2,  1'b1, 1'b0, 1'b0}, // R3 +3
    '{3'd0, 1'b0, B,     Z,  64'd10,Z,     Z, B+10,  1'b1, 1'b0, 1'b0}, // R3
    '{3'd2, 1'b1, B,     Z,  64'd6, Z,     Z, B+6,   1'b1, 1'b0, 1'b0}, // R3
    '{3'd2, 1'b0, B,     Z,  64'd6, Z,     Z, B+4,   1'b0, 1'b0, 1'b0}, // R4
    '{3'd0, 1'b0, B,     Z,  64'd8, Z,     Z, B+8,   1'b0, 1'b1, 1'b0}, // R5
    '{3'd3, 1'b0, B,     Z,  Z,     Z,     M, M-3,   1'b0, 1'b0, 1'b0}, // R8 C off
    '{3'd4, 1'b0, B,     Z,  Z,     64'd4, Z, B+4,   1'b0, 1'b0, 1'b1}, // R7 set
    '{3'd0, 1'b0, B,     Z,  NEG2,  Z,     Z, B-2,   1'b0, 1'b1, 1'b1}  // R2 negative
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [2:0]      in_kind = 3'd0;
  logic            in_taken = 1'b0;
  logic [XLEN-1:0] in_pc = '0, in_rs1 = '0, in_imm = '0, in_isa_wdata = '0, in_mepc = '0;
  logic            out_valid, rd_we, trap_valid, c_enable;
  logic [XLEN-1:0] next_pc, trap_epc, trap_tval;
  logic [5:0]      trap_cause;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xfer_align_unit u_xfer_align_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_taken(in_taken), .in_pc(in_pc), .in_rs1(in_rs1), .in_imm(in_imm),
    .in_isa_wdata(in_isa_wdata), .in_mepc(in_mepc), .out_valid(out_valid),
    .next_pc(next_pc), .rd_we(rd_we), .trap_valid(trap_valid),
    .trap_cause(trap_cause), .trap_epc(trap_epc), .trap_tval(trap_tval),
    .c_enable(c_enable)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic tk, input logic [63:0] pc,
                       input logic [63:0] rs1, input logic [63:0] imm,
                       input logic [63:0] wd, input logic [63:0] mepc);
    in_valid = 1'b1; in_kind = k; in_taken = tk; in_pc = pc;
    in_rs1 = rs1; in_imm = imm; in_isa_wdata = wd; in_mepc = mepc;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 c_enable", 64'(c_enable), 64'd1);
    chk("R9 out_valid", 64'(out_valid), 64'd0);
    chk("R9 trap_valid", 64'(trap_valid), 64'd0);
    chk("R9 rd_we", 64'(rd_we), 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].kind, TBL[i].taken, TBL[i].pc, TBL[i].rs1, TBL[i].imm,
            TBL[i].wdata, TBL[i].mepc);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R10 row%0d out_valid", i), 64'(out_valid), 64'd1);
      chk($sformatf("R2 row%0d next_pc", i), next_pc, TBL[i].exp_next);
      chk($sformatf("R3 row%0d trap_valid", i), 64'(trap_valid), 64'(TBL[i].exp_trap));
      chk($sformatf("R5 row%0d rd_we", i), 64'(rd_we), 64'(TBL[i].exp_rdwe));
      chk($sformatf("R7 row%0d c_enable", i), 64'(c_enable), 64'(TBL[i].exp_c));
      if (TBL[i].exp_trap) begin
        chk($sformatf("R6 row%0d epc", i), trap_epc, TBL[i].pc);
        chk($sformatf("R6 row%0d tval", i), trap_tval, TBL[i].exp_next);
        chk($sformatf("R6 row%0d cause", i), 64'(trap_cause), 64'd0);
      end
    end

    // R10: unknown kind
    drive(3'd5, 1'b0, B, Z, Z, Z, Z);
    @(posedge clk); @(negedge clk);
    chk("R10 kind5 out_valid", 64'(out_valid), 64'd0);
    chk("R10 kind5 rd_we", 64'(rd_we), 64'd0);

    // R10: valid low, then latency of a jump
    in_valid = 1'b0; in_kind = 3'd0; in_imm = 64'd8;
    @(posedge clk); @(negedge clk);
    chk("R10 idle out_valid", 64'(out_valid), 64'd0);
    drive(3'd0, 1'b0, B, Z, 64'd8, Z, Z);
    #1;
    chk("R10 no early out_valid", 64'(out_valid), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R10 one-cycle out_valid", 64'(out_valid), 64'd1);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 pulse ends", 64'(out_valid), 64'd0);

    // R1 R3: wrap-around target with C off
    drive(3'd4, 1'b0, B+8, Z, Z, Z, Z);
    @(posedge clk); @(negedge clk);
    chk("R7 clear accepted", 64'(c_enable), 64'd0);
    drive(3'd1, 1'b0, B, NEG2, 64'd4, Z, Z);
    @(posedge clk); @(negedge clk);
    chk("R3 wrap trap", 64'(trap_valid), 64'd1);
    chk("R6 wrap tval", trap_tval, 64'd2);
    chk("R1 wrap next_pc", next_pc, 64'd2);

    // R9: reset restores compressed enable
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 c_enable after reset", 64'(c_enable), 64'd1);
    chk("R9 trap after reset", 64'(trap_valid), 64'd0);

    finish_run();
  end
endmodule